// File: doc/BRIEF.md
# Power-Up Strap Latch Sequencer

This block orders the start-up of a clock generator. After an internal power-good indication arrives, it waits for an active-low strap strobe. While that strobe is held, it takes samples of the configuration straps: a three-level mode input, two frequency-select bits and a current-multiplier bit. When the strobe is released, the last sampled values are frozen. They stay frozen for as long as power stays good. The block decodes them into a CPU frequency code, a 66 MHz source select, a high-impedance flag and a test-mode flag.

Once the straps are frozen, the block turns on the PLL enable. It then counts a programmable number of settle cycles and turns on the output enable. If power-good drops at any point, everything returns to the idle state: both enables go low and the latched straps are cleared. Power-good and the strobe each pass through a reset-aware synchronizer before the sequencer uses them. The three-level input arrives already digitized as a two-bit code.

Top module: `pwrup_strap_seq`

## Requirements
- R1: During reset, and while power-good is low, `pll_en_o`, `out_en_o`, `straps_valid_o` and every decoded output are 0.
- R2: Straps are taken only while the synchronized strobe is low and power-good is high. The value present on the last strobe-low cycle is the one kept. Values applied before the strobe falls are not kept.
- R3: After the strobe has been released, strap changes and further strobe pulses have no effect on the decoded outputs or on the enables.
- R4: `pll_en_o` stays 0 while the strobe is still asserted. It rises only after the strobe is released, following at least one sample.
- R5: `out_en_o` rises exactly SETTLE_CYCLES clock cycles after `pll_en_o` rises. `out_en_o` is never 1 while `pll_en_o` is 0.
- R6: With the mode level low (code 00) or high (code 11), frequency bits 00, 01, 10 and 11 give `cpu_freq_o` codes 0, 1, 3 and 2. These codes mean 66, 100, 200 and 133 MHz, using the encoding 0=66, 1=100, 2=133, 3=200.
- R7: `ext66_src_o` is 1 only when the mode level is high. It selects the external 66 MHz input as the source for the buffered 66 MHz and PCI clocks. With the level low, the internal synthesizer is the source.
- R8: With the mode level mid and frequency bits 00, `hiz_o` is 1, `test_mode_o` is 0 and `cpu_freq_o` is 0.
- R9: With the mode level mid and frequency bits 01, `test_mode_o` is 1, `hiz_o` is 0 and `cpu_freq_o` is 0.
- R10: With the mode level mid and frequency bits 10 or 11, the block falls back to high impedance (`hiz_o`=1).
- R11: Level code 01 is mid, and the unused level code 10 is also treated as mid.
- R12: A drop of power-good clears both enables and `straps_valid_o` within SYNC_STAGES+2 cycles. When power returns, a fresh strobe takes new straps.
- R13: `mult_o` shows the latched multiplier strap once the straps are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good_i | input | 1 | Power-good indication, asynchronous |
| strap_strobe_n_i | input | 1 | Active-low level strobe that qualifies the straps |
| mode_lvl_i | input | 2 | Three-level mode code: 00 low, 01 mid, 11 high, 10 mid |
| fsel_i | input | 2 | Frequency-select straps |
| mult_i | input | 1 | Current-multiplier strap |
| pll_en_o | output | 1 | PLL enable |
| out_en_o | output | 1 | Clock output enable |
| straps_valid_o | output | 1 | At least one strap sample has been taken |
| cpu_freq_o | output | 2 | CPU frequency code (0=66, 1=100, 2=133, 3=200 MHz) |
| ext66_src_o | output | 1 | 66 MHz and PCI clocks taken from the external input |
| hiz_o | output | 1 | All outputs held in high impedance |
| test_mode_o | output | 1 | Test-clock divide mode |
| mult_o | output | 1 | Latched multiplier strap |

## Verification
The assertions assume that the straps are steady while the strobe is low. They also assume that power-good, once it has risen, stays high long enough for the synchronizer to pass it on. The stimulus meets both: the straps are changed only on falling clock edges and are held for several cycles around each strobe transition. Every power-good change is held for at least four cycles. The single case that moves straps during the strobe changes them several cycles before release, so the kept value is unambiguous.

// File: rtl/pwrup_strap_pkg.sv
// Package: shared types for the power-up strap sequencer.
// Assumes nothing beyond IEEE 1800-2017 enumerated types.
package pwrup_strap_pkg;

    // Sequencer states, in start-up order.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SAMPLE = 2'd1,
        SEQ_SETTLE = 2'd2,
        SEQ_RUN    = 2'd3
    } seq_state_e;

    // Digitized three-level input codes.
    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_ALT  = 2'b10;
    localparam logic [1:0] LVL_HIGH = 2'b11;

    // CPU frequency codes driven on the output.
    localparam logic [1:0] CPU_66  = 2'd0;
    localparam logic [1:0] CPU_100 = 2'd1;
    localparam logic [1:0] CPU_133 = 2'd2;
    localparam logic [1:0] CPU_200 = 2'd3;

    // Latched strap bundle.
    typedef struct packed {
        logic [1:0] lvl;
        logic [1:0] fsel;
        logic       mult;
    } strap_t;

endpackage

// File: rtl/pwrup_sync.sv
// Module: multi-stage synchronizer with a per-bit reset value.
// Assumes inputs are asynchronous level signals; output lags by STAGES cycles.
module pwrup_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= d_i;
            end
        end else begin : g_next
            // Later stages: shift along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwrup_capture.sv
// Module: strap capture register. Tracks the straps while sampling is
// enabled, holds them otherwise and clears on request.
// Assumes straps are steady around strobe edges.
module pwrup_capture
    import pwrup_strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear_i,
    input  logic   sample_i,
    input  strap_t straps_i,
    output strap_t straps_o,
    output logic   valid_o
);
    // Strap storage: clear has priority over sampling.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            straps_o <= '0;
            valid_o  <= 1'b0;
        end else if (sample_i) begin
            straps_o <= straps_i;
            valid_o  <= 1'b1;
        end
    end

    // R2: valid can only rise in a cycle that took a sample.
    assert_valid_from_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(sample_i));
endmodule

// File: rtl/pwrup_decode.sv
// Module: combinational decode of the latched straps into mode outputs.
// Assumes level code 10 is an unused encoding and treats it as mid.
module pwrup_decode
    import pwrup_strap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  strap_t     straps_i,
    input  logic       valid_i,
    output logic [1:0] cpu_freq_o,
    output logic       ext66_o,
    output logic       hiz_o,
    output logic       test_o,
    output logic       mult_o
);
    logic is_mid;

    // Level classification: both middle codes count as mid.
    always_comb begin
        is_mid = (straps_i.lvl == LVL_MID) || (straps_i.lvl == LVL_ALT);
    end

    // Mode and frequency decode, all zero until a sample exists.
    always_comb begin
        cpu_freq_o = CPU_66;
        ext66_o    = 1'b0;
        hiz_o      = 1'b0;
        test_o     = 1'b0;
        mult_o     = 1'b0;
        if (valid_i) begin
            mult_o = straps_i.mult;
            if (is_mid) begin
                if (straps_i.fsel == 2'b01) test_o = 1'b1;
                else                        hiz_o  = 1'b1;
            end else begin
                ext66_o = (straps_i.lvl == LVL_HIGH);
                unique case (straps_i.fsel)
                    2'b00:   cpu_freq_o = CPU_66;
                    2'b01:   cpu_freq_o = CPU_100;
                    2'b10:   cpu_freq_o = CPU_200;
                    default: cpu_freq_o = CPU_133;
                endcase
            end
        end
    end

    // R8 R9: high impedance and test mode never both on.
    assert_mode_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hiz_o, test_o}));
    // R7: external source only outside the mid modes.
    assert_ext_src_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext66_o |-> (!hiz_o && !test_o));
endmodule

// File: rtl/pwrup_settle_timer.sv
// Module: settle counter. Counts while run_i is high and pulses done_o on
// the last counted cycle; restarts from zero whenever run_i drops.
// Assumes LIMIT >= 1.
module pwrup_settle_timer #(
    parameter int unsigned LIMIT = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Cycle counter for the settle window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == LAST);

    // R5: the counter never passes its terminal value.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/pwrup_seq_fsm.sv
// Module: start-up state machine: idle -> sample -> settle -> run.
// Assumes synchronized power-good and strobe inputs.
module pwrup_seq_fsm
    import pwrup_strap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pg_i,
    input  logic strobe_n_i,
    input  logic valid_i,
    input  logic settle_done_i,
    output logic clear_o,
    output logic sample_o,
    output logic settle_run_o,
    output logic pll_en_o,
    output logic out_en_o
);
    seq_state_e state_q, state_d;

    // Next-state logic; loss of power-good overrides everything.
    always_comb begin
        state_d = state_q;
        if (!pg_i) begin
            state_d = SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE:   state_d = SEQ_SAMPLE;
                SEQ_SAMPLE: if (valid_i && strobe_n_i) state_d = SEQ_SETTLE;
                SEQ_SETTLE: if (settle_done_i) state_d = SEQ_RUN;
                default:    state_d = SEQ_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign clear_o      = (state_q == SEQ_IDLE);
    assign sample_o     = (state_q == SEQ_SAMPLE) && !strobe_n_i && pg_i;
    assign settle_run_o = (state_q == SEQ_SETTLE) && pg_i;
    assign pll_en_o     = (state_q == SEQ_SETTLE) || (state_q == SEQ_RUN);
    assign out_en_o     = (state_q == SEQ_RUN);

    // R4: the PLL starts only after a sample and with the strobe released.
    assert_pll_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en_o) |-> ($past(valid_i) && $past(strobe_n_i)));
    // R12: power-good loss clears both enables on the next cycle.
    assert_pg_drop_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_i |=> (!pll_en_o && !out_en_o));
endmodule

// File: rtl/pwrup_strap_seq.sv
// Module: top of the power-up strap latch sequencer.
// Assumes power-good and strobe are asynchronous; straps steady around strobe edges.
module pwrup_strap_seq
    import pwrup_strap_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 150000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good_i,
    input  logic       strap_strobe_n_i,
    input  logic [1:0] mode_lvl_i,
    input  logic [1:0] fsel_i,
    input  logic       mult_i,
    output logic       pll_en_o,
    output logic       out_en_o,
    output logic       straps_valid_o,
    output logic [1:0] cpu_freq_o,
    output logic       ext66_src_o,
    output logic       hiz_o,
    output logic       test_mode_o,
    output logic       mult_o
);
    logic [1:0] sync_raw, sync_q;
    logic       pg_s, strobe_n_s;
    logic       clear, sample, settle_run, settle_done;
    strap_t     straps_in, straps_q;

    assign sync_raw   = {pwr_good_i, strap_strobe_n_i};
    assign pg_s       = sync_q[1];
    assign strobe_n_s = sync_q[0];
    assign straps_in  = '{lvl: mode_lvl_i, fsel: fsel_i, mult: mult_i};

    pwrup_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sync_raw), .q_o(sync_q));

    pwrup_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pg_i(pg_s), .strobe_n_i(strobe_n_s),
        .valid_i(straps_valid_o), .settle_done_i(settle_done),
        .clear_o(clear), .sample_o(sample), .settle_run_o(settle_run),
        .pll_en_o(pll_en_o), .out_en_o(out_en_o));

    pwrup_capture u_cap (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .sample_i(sample),
        .straps_i(straps_in), .straps_o(straps_q), .valid_o(straps_valid_o));

    pwrup_settle_timer #(.LIMIT(SETTLE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(settle_run), .done_o(settle_done));

    pwrup_decode u_dec (
        .clk(clk), .rst_n(rst_n), .straps_i(straps_q), .valid_i(straps_valid_o),
        .cpu_freq_o(cpu_freq_o), .ext66_o(ext66_src_o), .hiz_o(hiz_o),
        .test_o(test_mode_o), .mult_o(mult_o));

    // R5: outputs are never enabled without the PLL.
    assert_oe_needs_pll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_o |-> pll_en_o);
    // R3: decoded straps stay put while the PLL is running.
    assert_straps_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en_o && $past(pll_en_o)) |->
        ($stable(cpu_freq_o) && $stable(hiz_o) && $stable(test_mode_o)
         && $stable(ext66_src_o) && $stable(mult_o)));
    // R1: nothing is decoded before a valid sample.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !straps_valid_o |-> (!hiz_o && !test_mode_o && !ext66_src_o && !mult_o
                             && cpu_freq_o == 2'd0));
endmodule

// File: tb/pwrup_strap_seq_tb.sv
module pwrup_strap_seq_tb;
    localparam int SETTLE = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg = 1'b0, strb_n = 1'b1, mult = 1'b0;
    logic [1:0] lvl = 2'b00, fsel = 2'b00;
    logic pll_en, out_en, valid, ext66, hiz, test, mult_o;
    logic [1:0] cpu;
    int checks = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    pwrup_strap_seq #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .strap_strobe_n_i(strb_n),
        .mode_lvl_i(lvl), .fsel_i(fsel), .mult_i(mult),
        .pll_en_o(pll_en), .out_en_o(out_en), .straps_valid_o(valid),
        .cpu_freq_o(cpu), .ext66_src_o(ext66), .hiz_o(hiz),
        .test_mode_o(test), .mult_o(mult_o));

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Expected decode, from the requirements: {cpu, ext66, hiz, test}.
    function automatic logic [4:0] expect_dec(logic [1:0] l, logic [1:0] f);
        logic mid;
        mid = (l == 2'b01) || (l == 2'b10);
        if (mid) return (f == 2'b01) ? 5'b00_0_0_1 : 5'b00_0_1_0;
        case (f)
            2'b00: return {2'd0, l == 2'b11, 2'b00};
            2'b01: return {2'd1, l == 2'b11, 2'b00};
            2'b10: return {2'd3, l == 2'b11, 2'b00};
            default: return {2'd2, l == 2'b11, 2'b00};
        endcase
    endfunction

    task automatic check_dec(string req, logic [1:0] l, logic [1:0] f, logic m);
        check(req, int'({cpu, ext66, hiz, test}), int'(expect_dec(l, f)));
        check(req, int'(mult_o), int'(m));
    endtask

    // Full bring-up: power cycle, strobe the straps, wait for enables.
    task automatic bring_up(logic [1:0] l, logic [1:0] f, logic m);
        int n;
        pg = 1'b0; strb_n = 1'b1;
        wait_n(5);
        pg = 1'b1; lvl = l; fsel = f; mult = m;
        wait_n(5);
        strb_n = 1'b0;
        wait_n(5);
        check("R4 pll held during strobe", int'(pll_en), 0);
        strb_n = 1'b1;
        n = 0;
        while (!pll_en && n < 20) begin @(negedge clk); n++; end
        check("R4 pll after release", int'(pll_en), 1);
        n = 0;
        while (!out_en && n < SETTLE + 10) begin @(negedge clk); n++; end
        check("R5 settle cycles", n, SETTLE);
    endtask

    task automatic t_reset();
        wait_n(3);
        check("R1 reset pll", int'(pll_en), 0);
        check("R1 reset oe", int'(out_en), 0);
        rst_n = 1'b1;
        strb_n = 1'b0; lvl = 2'b11; fsel = 2'b11; mult = 1'b1;
        wait_n(6);
        check("R1 pg low ignores strobe", int'({valid, pll_en, out_en, cpu, hiz, test, ext66, mult_o}), 0);
        strb_n = 1'b1;
    endtask

    task automatic t_freq_table();
        for (int l = 0; l < 4; l += 3)
            for (int f = 0; f < 4; f++) begin
                bring_up(2'(l), 2'(f), 1'(f));
                check_dec(l == 3 ? "R6 R7 R13 high level" : "R6 R7 R13 low level", 2'(l), 2'(f), 1'(f));
            end
    endtask

    task automatic t_mid();
        for (int l = 1; l < 3; l++)
            for (int f = 0; f < 4; f++) begin
                bring_up(2'(l), 2'(f), 1'b0);
                if (f == 0)      check_dec("R8 mid hiz", 2'(l), 2'(f), 1'b0);
                else if (f == 1) check_dec("R9 mid test", 2'(l), 2'(f), 1'b0);
                else             check_dec("R10 mid fallback", 2'(l), 2'(f), 1'b0);
                if (l == 2) check("R11 code 10 is mid", int'(hiz | test), 1);
            end
    endtask

    task automatic t_sample_window();
        pg = 1'b0; strb_n = 1'b1;
        wait_n(5);
        pg = 1'b1; lvl = 2'b11; fsel = 2'b10; mult = 1'b1;
        wait_n(6);
        check("R2 no sample before strobe", int'(valid), 0);
        lvl = 2'b00; fsel = 2'b01; mult = 1'b0;
        wait_n(2);
        strb_n = 1'b0;
        wait_n(5);
        lvl = 2'b11; fsel = 2'b11; mult = 1'b1;
        wait_n(5);
        strb_n = 1'b1;
        wait_n(SETTLE + 10);
        check("R2 last strobe value kept", int'(out_en), 1);
        check_dec("R2 kept straps", 2'b11, 2'b11, 1'b1);
        lvl = 2'b01; fsel = 2'b00; mult = 1'b0;
        strb_n = 1'b0;
        wait_n(6);
        check_dec("R3 ignored after latch", 2'b11, 2'b11, 1'b1);
        check("R3 enables kept", int'({pll_en, out_en}), 3);
        strb_n = 1'b1;
        wait_n(2);
    endtask

    task automatic t_pg_drop();
        bring_up(2'b11, 2'b01, 1'b1);
        pg = 1'b0;
        wait_n(4);
        check("R12 drop clears", int'({pll_en, out_en, valid, mult_o}), 0);
        bring_up(2'b00, 2'b10, 1'b0);
        check_dec("R12 fresh sample", 2'b00, 2'b10, 1'b0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_freq_table();
        t_mid();
        t_sample_window();
        t_pg_drop();
        finish_run();
    end
endmodule